// File: doc/BRIEF.md
# Password Program and Unlock Unit

This unit sits inside a flash command interface and guards a 64-bit password together with a protection-locked flag. The password is held as four 16-bit portions. The two lowest address bits of a data cycle pick the portion. Host bus cycles arrive as single-cycle write or read strobes with an address and 16 data bits. A two-write key prefix (address 0x555 with 0xAA, then address 0x2AA with 0x55), followed by a command byte written to 0x555, opens one of three sequences. The program sequence stores one portion. The verify sequence reads one portion back. The unlock sequence presents all four portions and releases the lock when they match.

Program and verify each handle exactly one portion, so the full four-cycle sequence is repeated per portion. Unlock is a seven-cycle sequence whose last four writes must address portions 0, 1, 2 and 3 in that order. While the unit is locked, the stored password can be neither changed nor read. Reset loads an all-ones password and sets the lock.

The controller has six states. S_IDLE waits for the first key write. S_PFX1 waits for the second key write. S_PFX2 waits for the command write. S_PROG takes one portion write. S_VFY takes one portion read. S_UNL takes the four portion writes, using a portion counter.

The transitions are:
- T_KEY1 (S_IDLE to S_PFX1)
- T_KEY2 (S_PFX1 to S_PFX2)
- T_BADKEY (S_PFX1 to S_IDLE)
- T_CMDPROG (S_PFX2 to S_PROG)
- T_CMDVFY (S_PFX2 to S_VFY)
- T_CMDUNL (S_PFX2 to S_UNL)
- T_BADCMD (S_PFX2 to S_IDLE)
- T_STORE (S_PROG to S_IDLE)
- T_READ and T_VABORT (S_VFY to S_IDLE)
- T_NEXT (S_UNL to S_UNL)
- T_ORDER (S_UNL to S_IDLE, portion out of order)
- T_LAST (S_UNL to S_IDLE, after portion 3)

Top module: `pwu_top`

## Requirements
- R1: A synchronous reset sets the locked flag to 1 and loads 0xFFFF into all four portions. The locked flag never goes from 0 to 1 except through reset.
- R2: Every sequence starts with a write of data low byte 0xAA to address 0x555, then a write of low byte 0x55 to address 0x2AA. On these key and command writes, data bits 15:8 are ignored. Any other write in place of a key or command write returns the unit to idle, and reads there are ignored.
- R3: After the key prefix, writing 0x38 to 0x555 and then a write of any 16-bit value stores all 16 bits into the portion given by addr[1:0], but only when the unit is unlocked.
- R4: While the unit is locked, the program data write leaves every stored portion unchanged.
- R5: After the key prefix, writing 0xC8 to 0x555 and then a read returns, in the same cycle, the portion given by addr[1:0] on rdata when the unit is unlocked. After that one read the unit is idle. A write in place of the read aborts to idle.
- R6: While the unit is locked, the verify read returns 0xFFFF.
- R7: After the key prefix, writing 0x28 to 0x555 and then four writes with addr[1:0] equal to 0, 1, 2 and 3 clears the locked flag on the fourth write, provided every 16-bit data value equals the stored portion.
- R8: If any of the four unlock words differs from its stored portion in any bit, the locked flag stays set.
- R9: An unlock write whose addr[1:0] is not the next expected portion ends the sequence without unlocking, and the unit returns to idle.
- R10: rdata is 0 in every cycle except the verify read cycle.
- R11: Each program or verify sequence serves exactly one portion. A further data write without a new prefix changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Bus write cycle strobe |
| rd_en_i | input | 1 | Bus read cycle strobe |
| addr_i | input | ADDR_W (12) | Bus address |
| wdata_i | input | WORD_W (16) | Write data |
| rdata_o | output | WORD_W (16) | Read data, valid on the verify read cycle, otherwise 0 |
| locked_o | output | 1 | Protection-locked flag |

## Verification
A controller stuck in the wrong state shows up at the ports within one sequence. Either a verify read returns 0 instead of a portion, or a later unlock fails to clear locked_o on its seventh write. A corrupted portion register or a wrong match flag is seen either on the next verify read of that portion, or as locked_o staying high (or falling) in the cycle after the final unlock write. The reference model predicts rdata_o in every cycle and locked_o after every edge, so any divergence is reported in the cycle it first appears.

// File: rtl/pwu_pkg.sv
package pwu_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PFX1,
        S_PFX2,
        S_PROG,
        S_VFY,
        S_UNL
    } state_t;

    localparam logic [11:0] A_KEY1 = 12'h555;
    localparam logic [11:0] A_KEY2 = 12'h2AA;
    localparam logic [7:0]  C_KEY1 = 8'hAA;
    localparam logic [7:0]  C_KEY2 = 8'h55;
    localparam logic [7:0]  C_PROG = 8'h38;
    localparam logic [7:0]  C_VFY  = 8'hC8;
    localparam logic [7:0]  C_UNL  = 8'h28;

endpackage

// File: rtl/pwu_store.sv
module pwu_store #(
    parameter int WORD_W  = 16,
    parameter int N_WORDS = 4,
    parameter int SEL_W   = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [SEL_W-1:0]          sel,
    input  logic [WORD_W-1:0]         wdata,
    output logic [WORD_W-1:0]         rword,
    output logic [WORD_W*N_WORDS-1:0] flat
);

    logic [WORD_W-1:0] words [N_WORDS];

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= '1;
            end else if (we && (sel == SEL_W'(g))) begin
                words[g] <= wdata;
            end
        end
        assign flat[g*WORD_W +: WORD_W] = words[g];
    end

    assign rword = words[sel];

endmodule

// File: rtl/pwu_seq.sv
module pwu_seq
    import pwu_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int WORD_W  = 16,
    parameter int N_WORDS = 4,
    parameter int SEL_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] cur_word,
    output logic              store_we,
    output state_t            state_o,
    output logic              locked_o,
    output logic [WORD_W-1:0] rdata
);

    localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(N_WORDS - 1);

    state_t           state_q, state_d;
    logic [SEL_W-1:0] idx_q, idx_d;
    logic             ok_q, ok_d;
    logic             locked_q;
    logic             unlock;

    logic             hit_k1, hit_k2, word_eq;
    logic [7:0]       cmd;
    logic [SEL_W-1:0] sel;

    assign hit_k1  = (addr == ADDR_W'(A_KEY1));
    assign hit_k2  = (addr == ADDR_W'(A_KEY2));
    assign cmd     = wdata[7:0];
    assign sel     = addr[SEL_W-1:0];
    assign word_eq = (wdata == cur_word);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            idx_q    <= '0;
            ok_q     <= 1'b0;
            locked_q <= 1'b1;
        end else begin
            state_q  <= state_d;
            idx_q    <= idx_d;
            ok_q     <= ok_d;
            locked_q <= locked_q && !unlock;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        ok_d    = ok_q;
        unlock  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (wr_en && hit_k1 && (cmd == C_KEY1)) state_d = S_PFX1;   // T_KEY1
            end
            S_PFX1: begin
                if (wr_en) state_d = (hit_k2 && (cmd == C_KEY2)) ? S_PFX2 : S_IDLE;
            end
            S_PFX2: begin
                if (wr_en) begin
                    state_d = S_IDLE;                                      // T_BADCMD
                    idx_d   = '0;
                    ok_d    = 1'b1;
                    if (hit_k1) begin
                        if (cmd == C_PROG)     state_d = S_PROG;         // T_CMDPROG
                        else if (cmd == C_VFY) state_d = S_VFY;          // T_CMDVFY
                        else if (cmd == C_UNL) state_d = S_UNL;          // T_CMDUNL
                    end
                end
            end
            S_PROG: begin
                if (wr_en) state_d = S_IDLE;                               // T_STORE
            end
            S_VFY: begin
                if (wr_en || rd_en) state_d = S_IDLE;                      // T_READ / T_VABORT
            end
            S_UNL: begin
                if (wr_en) begin
                    if (sel != idx_q) begin
                        state_d = S_IDLE;                                  // T_ORDER
                    end else if (idx_q == LAST_IDX) begin
                        state_d = S_IDLE;                                  // T_LAST
                        unlock  = ok_q && word_eq;
                    end else begin
                        idx_d = idx_q + 1'b1;                              // T_NEXT
                        ok_d  = ok_q && word_eq;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        store_we = (state_q == S_PROG) && wr_en && !locked_q;
        rdata    = '0;
        if ((state_q == S_VFY) && rd_en && !wr_en) begin
            rdata = locked_q ? '1 : cur_word;
        end
        state_o  = state_q;
        locked_o = locked_q;
    end

endmodule

// File: rtl/pwu_top.sv
module pwu_top
    import pwu_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int WORD_W  = 16,
    parameter int N_WORDS = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              locked_o
);

    localparam int SEL_W = $clog2(N_WORDS);
    localparam int PW_W  = WORD_W * N_WORDS;

    logic              store_we;
    logic [WORD_W-1:0] cur_word;
    logic [PW_W-1:0]   pw_flat_w;
    state_t            state_w;

    pwu_store #(
        .WORD_W (WORD_W),
        .N_WORDS(N_WORDS),
        .SEL_W  (SEL_W)
    ) u_store (
        .clk  (clk_i),
        .rst  (rst_i),
        .we   (store_we),
        .sel  (addr_i[SEL_W-1:0]),
        .wdata(wdata_i),
        .rword(cur_word),
        .flat (pw_flat_w)
    );

    pwu_seq #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .N_WORDS(N_WORDS),
        .SEL_W  (SEL_W)
    ) u_seq (
        .clk     (clk_i),
        .rst     (rst_i),
        .wr_en   (wr_en_i),
        .rd_en   (rd_en_i),
        .addr    (addr_i),
        .wdata   (wdata_i),
        .cur_word(cur_word),
        .store_we(store_we),
        .state_o (state_w),
        .locked_o(locked_o),
        .rdata   (rdata_o)
    );

endmodule

// File: rtl/pwu_chk.sv
module pwu_chk
    import pwu_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int PW_W   = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [WORD_W-1:0] rdata,
    input logic              locked,
    input state_t            state,
    input logic [PW_W-1:0]   pw_flat
);

    p_lock_never_rises_r1: assert property (@(posedge clk) disable iff (rst)
        !$rose(locked));

    p_idle_needs_write_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && !wr_en) |=> (state == S_IDLE));

    p_locked_store_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (locked && state == S_PROG && wr_en) |=> $stable(pw_flat));

    p_vfy_single_read_r5: assert property (@(posedge clk) disable iff (rst)
        (state == S_VFY && rd_en) |=> (state == S_IDLE));

    p_locked_masked_read_r6: assert property (@(posedge clk) disable iff (rst)
        locked |-> (rdata == '0 || rdata == '1));

    p_unlock_from_seq_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(state == S_UNL && wr_en));

    p_rdata_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (rdata != '0) |-> (rd_en && state == S_VFY));

endmodule

bind pwu_top pwu_chk #(.WORD_W(WORD_W), .PW_W(PW_W)) u_chk (
    .clk    (clk_i),
    .rst    (rst_i),
    .wr_en  (wr_en_i),
    .rd_en  (rd_en_i),
    .rdata  (rdata_o),
    .locked (locked_o),
    .state  (state_w),
    .pw_flat(pw_flat_w)
);

// File: tb/pwu_top_tb_top.sv
module pwu_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        locked;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_tag = "R1";

    // reference model: 0 idle, 1 after key1, 2 after key2, 3 program, 4 verify, 5 unlock
    logic [15:0] m_pw [4];
    int          m_mode;
    int          m_idx;
    bit          m_ok;
    bit          m_locked;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwu_top dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .locked_o(locked)
    );

    task automatic check(string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", cur_tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 4; k++) m_pw[k] = 16'hFFFF;
        m_locked = 1;
        m_mode = 0;
        m_idx = 0;
        m_ok = 0;
    endtask

    task automatic step(bit w, bit r, logic [11:0] a, logic [15:0] d);
        logic [15:0] exp_rd;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        #1;
        exp_rd = 16'h0000;
        if (m_mode == 4 && r && !w) exp_rd = m_locked ? 16'hFFFF : m_pw[a[1:0]];
        check("rdata", rdata, exp_rd);
        @(posedge clk);
        if (w) begin
            case (m_mode)
                0: if (a == 12'h555 && d[7:0] == 8'hAA) m_mode = 1;
                1: m_mode = (a == 12'h2AA && d[7:0] == 8'h55) ? 2 : 0;
                2: begin
                    m_mode = 0; m_idx = 0; m_ok = 1;
                    if (a == 12'h555) begin
                        if (d[7:0] == 8'h38) m_mode = 3;
                        else if (d[7:0] == 8'hC8) m_mode = 4;
                        else if (d[7:0] == 8'h28) m_mode = 5;
                    end
                end
                3: begin
                    if (!m_locked) m_pw[a[1:0]] = d;
                    m_mode = 0;
                end
                4: m_mode = 0;
                5: begin
                    if (int'(a[1:0]) != m_idx) m_mode = 0;
                    else if (m_idx == 3) begin
                        if (m_ok && d == m_pw[3]) m_locked = 0;
                        m_mode = 0;
                    end else begin
                        m_ok = m_ok && (d == m_pw[m_idx]);
                        m_idx++;
                    end
                end
                default: m_mode = 0;
            endcase
        end else if (r && m_mode == 4) begin
            m_mode = 0;
        end
        #1;
        check("locked", {15'd0, locked}, {15'd0, m_locked});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; wr_en = 0; rd_en = 0;
        @(posedge clk); @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 0;
        check("reset locked", {15'd0, locked}, 16'd1);
        check("reset rdata", rdata, 16'h0000);
    endtask

    task automatic pfx();
        step(1, 0, 12'h555, 16'h00AA);
        step(1, 0, 12'h2AA, 16'h0055);
    endtask

    task automatic prog(logic [1:0] s, logic [15:0] d);
        pfx();
        step(1, 0, 12'h555, 16'h0038);
        step(1, 0, {10'h0A0, s}, d);
    endtask

    task automatic vfy(logic [1:0] s);
        pfx();
        step(1, 0, 12'h555, 16'h00C8);
        step(0, 1, {10'h000, s}, 16'h0);
    endtask

    task automatic unl(logic [15:0] w0, logic [15:0] w1, logic [15:0] w2, logic [15:0] w3);
        pfx();
        step(1, 0, 12'h555, 16'h0028);
        step(1, 0, 12'h100, w0);
        step(1, 0, 12'h101, w1);
        step(1, 0, 12'h102, w2);
        step(1, 0, 12'h103, w3);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        cur_tag = "R1"; do_reset();
        step(0, 0, 12'h0, 16'h0);
        step(0, 1, 12'h555, 16'h0);
        cur_tag = "R6"; vfy(2'd0);
        cur_tag = "R4"; prog(2'd0, 16'h1234);
        cur_tag = "R7"; unl(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        check("R7 unlocked", {15'd0, locked}, 16'd0);
        cur_tag = "R3";
        prog(2'd0, 16'hA5A5);
        prog(2'd1, 16'h5A5A);
        prog(2'd2, 16'h8001);
        prog(2'd3, 16'hAB00);
        cur_tag = "R5";
        vfy(2'd3); vfy(2'd2); vfy(2'd1); vfy(2'd0);
        step(0, 1, 12'h001, 16'h0);
        pfx(); step(1, 0, 12'h555, 16'h00C8); step(1, 0, 12'h001, 16'h0);
        step(0, 1, 12'h001, 16'h0);
        cur_tag = "R11";
        prog(2'd1, 16'h0F0F);
        step(1, 0, 12'h001, 16'h0000);
        vfy(2'd1);
        cur_tag = "R2";
        step(1, 0, 12'h555, 16'h12AA);
        step(1, 0, 12'h2AA, 16'hFF55);
        step(1, 0, 12'h555, 16'h7738);
        step(1, 0, 12'h002, 16'hC3C3);
        vfy(2'd2);
        step(1, 0, 12'h555, 16'h00AA);
        step(0, 1, 12'h2AA, 16'h0);
        step(1, 0, 12'h2AA, 16'h0055);
        step(1, 0, 12'h554, 16'h0038);
        step(1, 0, 12'h000, 16'h1111);
        vfy(2'd0);
        cur_tag = "R10";
        step(0, 1, 12'h000, 16'h0);
        step(0, 0, 12'h000, 16'h0);
        cur_tag = "R1"; do_reset();
        vfy(2'd0);
        cur_tag = "R8"; unl(16'hFFFF, 16'hFFFF, 16'h7FFF, 16'hFFFF);
        check("R8 still locked", {15'd0, locked}, 16'd1);
        unl(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFE);
        cur_tag = "R9";
        pfx();
        step(1, 0, 12'h555, 16'h0028);
        step(1, 0, 12'h000, 16'hFFFF);
        step(1, 0, 12'h002, 16'hFFFF);
        step(1, 0, 12'h002, 16'hFFFF);
        step(1, 0, 12'h003, 16'hFFFF);
        check("R9 still locked", {15'd0, locked}, 16'd1);
        cur_tag = "R2";
        step(1, 0, 12'h555, 16'h00AA);
        step(1, 0, 12'h2AA, 16'h0054);
        step(1, 0, 12'h555, 16'h0028);
        step(1, 0, 12'h000, 16'hFFFF);
        step(1, 0, 12'h001, 16'hFFFF);
        step(1, 0, 12'h002, 16'hFFFF);
        step(1, 0, 12'h003, 16'hFFFF);
        check("R2 still locked", {15'd0, locked}, 16'd1);
        cur_tag = "R7"; unl(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        check("R7 unlocked again", {15'd0, locked}, 16'd0);
        vfy(2'd3);
        step(0, 0, 12'h0, 16'h0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule